// File: doc/BRIEF.md
# Reset Jump Vector Injector

This block sits beside the data bus of an 8-bit processor that always begins execution at address 0000H after reset. Instead of letting the first instruction come from memory, it hands the processor a three-byte unconditional absolute jump (opcode C3H followed by a little-endian 16-bit target). The target lies on a 4 KB boundary picked by a 4-bit selector. The processor then carries on from that target, and the block stays silent until the next reset.

The processor's memory read strobe tells the block when a byte is being fetched. While an injected byte is due, the block raises an override flag and presents the byte, and the data path then uses it in place of memory. Each injected byte moves on when its read strobe ends. An enable strap, sampled together with the selector while reset is held, can switch the whole mechanism off. In that case the processor simply fetches from 0000H.

Top module: `reset_jump_injector`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `ovr_drive` is 0 and `ovr_data` is 00H. Whenever `ovr_drive` is 0, `ovr_data` is 00H.
- R2: With the enable strap high at reset release, the first read strobe after reset yields `ovr_drive`=1 and `ovr_data`=C3H.
- R3: The second read strobe after reset yields `ovr_drive`=1 and `ovr_data`=00H, which is the low target byte. The lower 12 target bits are always zero.
- R4: The third read strobe after reset yields `ovr_drive`=1 and `ovr_data`={sel[3:0], 4'b0000}, which is the high target byte. The target is therefore sel×1000H.
- R5: After the third injected byte has ended, further read strobes give `ovr_drive`=0 until the next reset.
- R6: If the enable strap is low at reset release, no read strobe gives `ovr_drive`=1 until a later reset that sees the strap high.
- R7: A read strobe held high for several cycles keeps the same override byte for its whole duration. The sequence advances only on the strobe's falling edge, meaning the first cycle in which the strobe is sampled low after being high.
- R8: Asserting reset in the middle of the sequence restarts it, so the next read strobe after release yields C3H.
- R9: The selector and enable values are taken from the last clock edge at which reset is high. Changing them after release has no effect on the injected target.
- R10: The outputs are registered. `ovr_drive` rises one clock edge after the strobe is first sampled high and falls at the edge where the strobe is first sampled low.
- R11: Every one of the 16 selector values produces the jump target sel×1000H.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; restarts the injection |
| jump_en | input | 1 | Enable strap for injection, sampled while reset is high |
| target_sel | input | 4 | Target address bits 15..12, sampled while reset is high |
| rd_strobe | input | 1 | High while the processor performs a memory read |
| ovr_data | output | 8 | Byte to place on the processor data bus when overriding |
| ovr_drive | output | 1 | High when `ovr_data` must replace memory data |

## Verification
A corrupted phase counter shows up at the very next read strobe, as a wrong byte or an override that appears out of place. A stuck phase shows as a repeated byte or as an override that never stops. A stray advance while a strobe is held appears as a byte change within that strobe. A badly captured selector is visible only at the third read, in the high target byte. That is why every selector value is swept. A leaky enable shows as any override at all after a disabled reset. A broken registering stage shifts `ovr_drive` by one cycle around the strobe's edges, and this is caught by sampling just before and just after each of those edges.

// File: rtl/rji_pkg.sv
package rji_pkg;
  localparam logic [7:0] JUMP_OPCODE = 8'hC3;

  typedef enum logic [1:0] {
    PH_OPCODE = 2'd0,
    PH_LOW    = 2'd1,
    PH_HIGH   = 2'd2,
    PH_DONE   = 2'd3
  } phase_t;
endpackage

// File: rtl/rji_strobe_edge.sv
module rji_strobe_edge (
  input  logic clk,
  input  logic rst,
  input  logic rd_strobe,
  output logic rd_trail
);
  logic rd_q;

  always_ff @(posedge clk) begin
    if (rst) rd_q <= 1'b0;
    else     rd_q <= rd_strobe;
  end

  assign rd_trail = rd_q & ~rd_strobe;
endmodule

// File: rtl/rji_sequencer.sv
module rji_sequencer
  import rji_pkg::*;
#(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             jump_en,
  input  logic [SEL_W-1:0] target_sel,
  input  logic             rd_trail,
  output phase_t           phase,
  output logic             inject,
  output logic [SEL_W-1:0] sel_q
);
  logic en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_OPCODE;
      en_q  <= jump_en;
      sel_q <= target_sel;
    end else if (rd_trail && en_q && phase != PH_DONE) begin
      phase <= phase_t'(phase + 2'd1);
    end
  end

  assign inject = en_q && (phase != PH_DONE);

  // R7: phase changes only at a strobe's trailing edge
  assert_phase_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !rd_trail |=> $stable(phase));

  // R5: once done, the sequence never restarts without reset
  assert_no_rearm_R5: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DONE) |=> (phase == PH_DONE));

  // R8: reset always returns the sequence to the opcode byte
  assert_restart_R8: assert property (@(posedge clk)
    rst |=> (phase == PH_OPCODE));

  // R9: captured selector holds outside reset
  assert_sel_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(sel_q));
endmodule

// File: rtl/rji_byte_gen.sv
module rji_byte_gen
  import rji_pkg::*;
#(
  parameter int SEL_W  = 4,
  parameter int ADDR_W = 16
) (
  input  phase_t           phase,
  input  logic [SEL_W-1:0] sel_q,
  output logic [7:0]       jump_byte
);
  localparam int ZERO_W = ADDR_W - SEL_W;

  logic [ADDR_W-1:0] target;
  assign target = {sel_q, {ZERO_W{1'b0}}};

  always_comb begin
    case (phase)
      PH_OPCODE: jump_byte = JUMP_OPCODE;
      PH_LOW:    jump_byte = target[7:0];
      PH_HIGH:   jump_byte = target[ADDR_W-1 -: 8];
      default:   jump_byte = 8'h00;
    endcase
  end
endmodule

// File: rtl/reset_jump_injector.sv
module reset_jump_injector
  import rji_pkg::*;
#(
  parameter int SEL_W  = 4,
  parameter int ADDR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             jump_en,
  input  logic [SEL_W-1:0] target_sel,
  input  logic             rd_strobe,
  output logic [7:0]       ovr_data,
  output logic             ovr_drive
);
  logic             rd_trail;
  phase_t           phase;
  logic             inject;
  logic [SEL_W-1:0] sel_q;
  logic [7:0]       jump_byte;

  rji_strobe_edge u_edge (
    .clk       (clk),
    .rst       (rst),
    .rd_strobe (rd_strobe),
    .rd_trail  (rd_trail)
  );

  rji_sequencer #(.SEL_W(SEL_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .jump_en    (jump_en),
    .target_sel (target_sel),
    .rd_trail   (rd_trail),
    .phase      (phase),
    .inject     (inject),
    .sel_q      (sel_q)
  );

  rji_byte_gen #(.SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_bytes (
    .phase     (phase),
    .sel_q     (sel_q),
    .jump_byte (jump_byte)
  );

  always_ff @(posedge clk) begin
    if (rst || !(inject && rd_strobe)) begin
      ovr_drive <= 1'b0;
      ovr_data  <= 8'h00;
    end else begin
      ovr_drive <= 1'b1;
      ovr_data  <= jump_byte;
    end
  end

  // R10: override only follows a sampled read strobe
  assert_drive_follows_read_R10: assert property (@(posedge clk) disable iff (rst)
    ovr_drive |-> $past(rd_strobe));

  // R5: no override once the sequencer is idle
  assert_quiet_idle_R5: assert property (@(posedge clk) disable iff (rst)
    !inject |=> !ovr_drive);

  // R1: data bus output is zero whenever not overriding
  assert_zero_when_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !ovr_drive |-> (ovr_data == 8'h00));
endmodule

// File: tb/reset_jump_injector_bench.sv
module reset_jump_injector_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       jump_en = 1'b1;
  logic [3:0] target_sel = 4'h0;
  logic       rd_strobe = 1'b0;
  logic [7:0] ovr_data;
  logic       ovr_drive;

  int n_tests = 0;
  int n_fail  = 0;
  bit done_flag = 1'b0;

  always #2 clk = ~clk;

  reset_jump_injector u_reset_jump_injector (
    .clk        (clk),
    .rst        (rst),
    .jump_en    (jump_en),
    .target_sel (target_sel),
    .rd_strobe  (rd_strobe),
    .ovr_data   (ovr_data),
    .ovr_drive  (ovr_drive)
  );

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("[TB] FAIL %s: actual drive/data=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reset with given strap values; checks R1 while held and just after
  task automatic do_reset(input logic en, input logic [3:0] sel);
    @(negedge clk);
    rst = 1'b1; jump_en = en; target_sel = sel;
    repeat (3) @(negedge clk);
    check("R1 in reset", {ovr_drive, ovr_data}, 9'h000);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", {ovr_drive, ovr_data}, 9'h000);
  endtask

  // one read strobe of len cycles; every sample must equal exp
  task automatic do_read(input int len, input logic [8:0] exp, input string req);
    @(negedge clk);
    rd_strobe = 1'b1;
    #1 check("R10 no early drive", {ovr_drive, ovr_data}, 9'h000);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      check((i == 0) ? req : "R7 byte held", {ovr_drive, ovr_data}, exp);
    end
    rd_strobe = 1'b0;
    @(negedge clk);
    check("R10 drive drops", {ovr_drive, ovr_data}, 9'h000);
  endtask

  task automatic t_reset_state;
    do_reset(1'b1, 4'h3);
  endtask

  task automatic t_all_targets;
    for (int s = 0; s < 16; s++) begin
      do_reset(1'b1, 4'(s));
      do_read(1, 9'h1C3, "R2 opcode");
      do_read(1, 9'h100, "R3 low byte");
      do_read(1, {1'b1, 4'(s), 4'h0}, "R4/R11 high byte");
      do_read(1, 9'h000, "R5 idle after jump");
    end
  endtask

  task automatic t_disabled;
    do_reset(1'b0, 4'hC);
    for (int i = 0; i < 4; i++) do_read(1, 9'h000, "R6 disabled");
  endtask

  task automatic t_long_strobe;
    do_reset(1'b1, 4'h7);
    do_read(4, 9'h1C3, "R7 long opcode");
    do_read(3, 9'h100, "R7 long low");
    do_read(5, 9'h170, "R7 long high");
    do_read(2, 9'h000, "R5 after long");
  endtask

  task automatic t_mid_reset;
    do_reset(1'b1, 4'h9);
    do_read(1, 9'h1C3, "R2 opcode");
    do_read(1, 9'h100, "R3 low byte");
    do_reset(1'b1, 4'hB);
    do_read(1, 9'h1C3, "R8 restart opcode");
    do_read(1, 9'h100, "R8 restart low");
    do_read(1, 9'h1B0, "R8 restart high");
  endtask

  task automatic t_sel_change;
    do_reset(1'b1, 4'h5);
    target_sel = 4'hA;
    jump_en = 1'b0;
    do_read(1, 9'h1C3, "R9 opcode");
    target_sel = 4'hF;
    do_read(1, 9'h100, "R9 low");
    do_read(1, 9'h150, "R9 sampled selector");
  endtask

  initial begin
    t_reset_state();
    t_all_targets();
    t_disabled();
    t_long_strobe();
    t_mid_reset();
    t_sel_change();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1'b1;
      n_tests++;
      n_fail++;
      $display("[TB] FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule